// File: doc/BRIEF.md
# Delta-Sigma Converter Frame Reader

This block is the host side of a three-wire link to a delta-sigma converter: a chip-select output, a serial clock output and a data input. On a start command it drops chip select and looks at the data line. The converter drives this line high while a conversion is still running and low once a result can be read. If the line is high, the reader releases chip select, waits a programmable gap and tries again. If it is low, the reader clocks in a 24-bit frame, most significant bit first. It then releases chip select and gives a one-cycle result strobe.

With the strobe come the decoded frame contents: a signed two's-complement value, a positive flag, overrange and underrange flags, and a frame-error flag. The frame-error flag is raised when either leading status bit reads high. After reset the reader waits out a power-on delay set by a parameter, so that the converter's own start-up reset has ended before the first poll. The serial clock rate and the retry gap come from configuration inputs. An abort input returns the reader to idle at the next clock edge, whatever state it is in.

Top module: `sdadc_reader`

## Requirements
- R1: From reset, and for PWRUP_CYCLES cycles after reset is released, `busy` is high, `cs_n` is high and `sclk` is low. After that window the reader is idle (`busy` low).
- R2: When idle, a `start` pulse drops `cs_n` at the next edge. `cs_n` then stays low, with `sclk` low, for `div_cfg`+1 cycles, and `sdo` is sampled at the edge that ends this window. A `start` that arrives while `busy` is high is ignored.
- R3: If `sdo` is sampled high at the end of a poll, `cs_n` goes high for `gap_cfg`+1 cycles. A new poll window as in R2 then begins.
- R4: If `sdo` is sampled low at the end of a poll, `cs_n` stays low and `sclk` makes 24 pulses. Each half period lasts `div_cfg`+1 cycles, and `sclk` starts low. `sdo` is captured at each rising step, and the first captured bit lands in frame bit 23.
- R5: At the edge that completes the 24th `sclk` low-going step, `cs_n` rises and `res_valid` goes high for exactly one cycle. `busy` drops in the following cycle.
- R6: `res_ferr` is high with `res_valid` when frame bit 23 or frame bit 22 was captured high.
- R7: `res_pos` equals frame bit 21, the sign bit: high for a positive input.
- R8: `res_over` is high when frame bits 21 and 20 are both high. `res_under` is high when both are low. The two flags are never high together.
- R9: `res_data` is a 21-bit two's-complement value. When frame bit 21 is high it equals frame bits 20..0 read as an unsigned number; otherwise it equals that number minus 2^21. The result is then clamped to the range -2^20 .. 2^20-1.
- R10: An `abort` in any state makes `cs_n` high, `sclk` low and `busy` low at the next edge.
- R11: `sclk` is never high while `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a poll-and-read sequence when idle |
| abort | input | 1 | Synchronous return to idle |
| div_cfg | input | DIV_W | Serial clock half period minus one, in system cycles |
| gap_cfg | input | GAP_W | Retry gap minus one, in system cycles |
| cs_n | output | 1 | Chip select to converter, active low |
| sclk | output | 1 | Serial clock to converter |
| sdo | input | 1 | Serial data from converter |
| busy | output | 1 | High in every state except idle |
| res_valid | output | 1 | One-cycle strobe marking a new frame |
| res_data | output | 21 | Signed, clamped conversion value |
| res_pos | output | 1 | Sign bit of the frame |
| res_over | output | 1 | Input above positive full scale |
| res_under | output | 1 | Input below negative full scale |
| res_ferr | output | 1 | A leading status bit read high |

## Verification
The assertions assume that `div_cfg` and `gap_cfg` hold still while `busy` is high. They also assume that the converter changes `sdo` only when chip select falls or on a low-going `sclk` step, never close to a system edge at which the reader samples. The bench programs both settings only while the reader is idle. Its converter model moves the data line only on those two events, so every sample the reader takes sees a settled level.

// File: rtl/sdadc_pkg.sv
package sdadc_pkg;

  localparam int FRAME_W = 24;
  localparam int RES_W   = 21;
  localparam int B_EOC   = 23;
  localparam int B_ZERO  = 22;
  localparam int B_SIGN  = 21;
  localparam int B_TOP   = 20;

  typedef enum logic [2:0] {
    ST_PWRUP, ST_IDLE, ST_POLL, ST_GAP, ST_SHIFT, ST_DONE
  } rd_state_e;

  typedef struct packed {
    logic                    ferr;
    logic                    pos;
    logic                    over;
    logic                    under;
    logic signed [RES_W-1:0] value;
  } rd_result_t;

  // Turn a captured frame into flags and a clamped signed value.
  function automatic rd_result_t decode_frame(input logic [FRAME_W-1:0] f);
    rd_result_t r;
    r.ferr  = f[B_EOC] | f[B_ZERO];
    r.pos   = f[B_SIGN];
    r.over  = f[B_SIGN] & f[B_TOP];
    r.under = ~f[B_SIGN] & ~f[B_TOP];
    if (r.over)
      r.value = {1'b0, {(RES_W-1){1'b1}}};
    else if (r.under)
      r.value = {1'b1, {(RES_W-1){1'b0}}};
    else
      r.value = {~f[B_SIGN], f[B_TOP-1:0]};
    return r;
  endfunction

endpackage

// File: rtl/sdadc_timer.sv
module sdadc_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt;

  assign hit = (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (clr | hit) cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sdadc_shifter.sv
module sdadc_shifter #(
  parameter int N  = 24,
  localparam int CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          shift,
  input  logic          din,
  output logic [N-1:0]  frame,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame <= '0;
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else if (shift) begin
      frame <= {frame[N-2:0], din};
      count <= count + 1'b1;
    end
  end

  // R4: the sequencer never asks for more bits than a frame holds
  p_shift_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    shift |-> (count < CW'(N)));
endmodule

// File: rtl/sdadc_reader.sv
module sdadc_reader
  import sdadc_pkg::*;
#(
  parameter int DIV_W        = 8,
  parameter int GAP_W        = 16,
  parameter int PWRUP_CYCLES = 100000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    abort,
  input  logic [DIV_W-1:0]        div_cfg,
  input  logic [GAP_W-1:0]        gap_cfg,
  output logic                    cs_n,
  output logic                    sclk,
  input  logic                    sdo,
  output logic                    busy,
  output logic                    res_valid,
  output logic signed [RES_W-1:0] res_data,
  output logic                    res_pos,
  output logic                    res_over,
  output logic                    res_under,
  output logic                    res_ferr
);
  localparam int PWR_W = $clog2(PWRUP_CYCLES + 1);
  localparam int MX_DG = (DIV_W > GAP_W) ? DIV_W : GAP_W;
  localparam int CNT_W = (PWR_W > MX_DG) ? PWR_W : MX_DG;
  localparam int BC_W  = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] PWR_LIM = CNT_W'(PWRUP_CYCLES - 1);

  rd_state_e        state, nxt;
  logic             sclk_q, sclk_nxt;
  logic [CNT_W-1:0] lim;
  logic             half_tick;
  logic             tmr_clr;
  logic             cap_en, cap_clr;
  logic [FRAME_W-1:0] frame;
  logic [BC_W-1:0]  bits_seen;
  rd_result_t       res;

  // Named internal events for the assertions
  logic poll_ready, poll_busy, frame_done;
  assign poll_ready = (state == ST_POLL) && half_tick && !sdo && !abort;
  assign poll_busy  = (state == ST_POLL) && half_tick &&  sdo && !abort;
  assign frame_done = (state == ST_SHIFT) && (nxt == ST_DONE);

  always_comb begin
    unique case (state)
      ST_PWRUP: lim = PWR_LIM;
      ST_GAP:   lim = CNT_W'(gap_cfg);
      default:  lim = CNT_W'(div_cfg);
    endcase
  end

  always_comb begin
    nxt      = state;
    sclk_nxt = sclk_q;
    cap_en   = 1'b0;
    unique case (state)
      ST_PWRUP: if (half_tick) nxt = ST_IDLE;
      ST_IDLE:  if (start)     nxt = ST_POLL;
      ST_POLL:  if (half_tick) nxt = sdo ? ST_GAP : ST_SHIFT;
      ST_GAP:   if (half_tick) nxt = ST_POLL;
      ST_SHIFT: begin
        if (half_tick) begin
          if (!sclk_q) begin
            sclk_nxt = 1'b1;
            cap_en   = 1'b1;
          end else begin
            sclk_nxt = 1'b0;
            if (bits_seen == BC_W'(FRAME_W)) nxt = ST_DONE;
          end
        end
      end
      ST_DONE:  nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
    if (abort) begin
      nxt      = ST_IDLE;
      sclk_nxt = 1'b0;
      cap_en   = 1'b0;
    end
  end

  assign tmr_clr = (nxt != state);
  assign cap_clr = (nxt == ST_SHIFT) && (state != ST_SHIFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_PWRUP;
      sclk_q <= 1'b0;
    end else begin
      state  <= nxt;
      sclk_q <= sclk_nxt;
    end
  end

  sdadc_timer #(.W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .limit (lim),
    .hit   (half_tick)
  );

  sdadc_shifter #(.N(FRAME_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cap_clr),
    .shift (cap_en),
    .din   (sdo),
    .frame (frame),
    .count (bits_seen)
  );

  assign res       = decode_frame(frame);
  assign cs_n      = !((state == ST_POLL) || (state == ST_SHIFT));
  assign sclk      = sclk_q;
  assign busy      = (state != ST_IDLE);
  assign res_valid = (state == ST_DONE);
  assign res_data  = res.value;
  assign res_pos   = res.pos;
  assign res_over  = res.over;
  assign res_under = res.under;
  assign res_ferr  = res.ferr;

  // R11: the serial clock only moves while the converter is selected
  p_sclk_selected_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);

  // R10: abort lands in idle with the link released
  p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (cs_n && !sclk && !busy));

  // R5: the strobe lasts one cycle and the reader is idle afterwards
  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> (!res_valid && !busy));

  // R5: a strobe only follows a complete frame of captured bits
  p_valid_full_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (bits_seen == BC_W'(FRAME_W)));

  // R4: a ready poll leads into the shift phase with the clock low
  p_ready_keeps_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    poll_ready |=> (!cs_n && !sclk));

  // R3: a busy poll releases chip select
  p_busy_releases_r3: assert property (@(posedge clk) disable iff (!rst_n)
    poll_busy |=> cs_n);

  // R2: chip select falls with the serial clock low
  p_cs_fall_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> !sclk);

  // R8: overrange and underrange exclude each other
  p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !(res_over && res_under));

  // R5: the frame ends with a low-going clock step and chip select release
  p_done_after_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (res_valid && cs_n && !sclk));
endmodule

// File: tb/sdadc_reader_bench.sv
module sdadc_reader_bench;
  localparam int PWR = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, abort = 1'b0;
  logic [7:0]  div_cfg = '0;
  logic [15:0] gap_cfg = '0;
  logic sdo = 1'b1;
  logic cs_n, sclk, busy, res_valid, res_pos, res_over, res_under, res_ferr;
  logic signed [20:0] res_data;

  always #5 clk = ~clk;

  sdadc_reader #(.DIV_W(8), .GAP_W(16), .PWRUP_CYCLES(PWR)) u_sdadc_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .div_cfg(div_cfg), .gap_cfg(gap_cfg), .cs_n(cs_n), .sclk(sclk),
    .sdo(sdo), .busy(busy), .res_valid(res_valid), .res_data(res_data),
    .res_pos(res_pos), .res_over(res_over), .res_under(res_under),
    .res_ferr(res_ferr)
  );

  int n_checks = 0, n_fails = 0, cycles = 0;
  logic chk_on = 1'b0;
  logic exp_cs = 1'b1, exp_sclk = 1'b0, exp_busy = 1'b1, exp_valid = 1'b0;
  logic [23:0] exp_frame = '0;
  string cur_tag = "R1";

  // Converter model
  logic [23:0] conv_frame = '0;
  int polls_left = 0, bit_idx = 0;
  always @(negedge cs_n) begin
    bit_idx = 23;
    if (polls_left > 0) begin
      polls_left = polls_left - 1;
      sdo = 1'b1;
    end else sdo = 1'b0;
  end
  always @(posedge cs_n) sdo = 1'b1;
  always @(negedge sclk) if (!cs_n && bit_idx > 0) begin
    bit_idx = bit_idx - 1;
    sdo = conv_frame[bit_idx];
  end

  task automatic chk(input string tag, input int act, input int expv);
    n_checks++;
    if (act != expv) begin
      n_fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cycles, act, expv);
    end
  endtask

  function automatic int want_value(input logic [23:0] f);
    int raw;
    raw = int'(f[20:0]);
    if (!f[21]) raw = raw - (1 << 21);
    if (raw > (1 << 20) - 1) raw = (1 << 20) - 1;
    if (raw < -(1 << 20)) raw = -(1 << 20);
    return raw;
  endfunction

  always @(negedge clk) if (chk_on) begin
    chk({cur_tag, " cs_n"}, int'(cs_n), int'(exp_cs));
    chk({cur_tag, " sclk"}, int'(sclk), int'(exp_sclk));
    chk({cur_tag, " busy"}, int'(busy), int'(exp_busy));
    chk("R5 res_valid", int'(res_valid), int'(exp_valid));
    chk("R11 sclk while deselected", int'(sclk && cs_n), 0);
    if (exp_valid) begin
      chk("R6 res_ferr", int'(res_ferr), int'(exp_frame[23] || exp_frame[22]));
      chk("R7 res_pos", int'(res_pos), int'(exp_frame[21]));
      chk("R8 res_over", int'(res_over), int'(exp_frame[21] && exp_frame[20]));
      chk("R8 res_under", int'(res_under), int'(!exp_frame[21] && !exp_frame[20]));
      chk("R9 res_data", int'(res_data), want_value(exp_frame));
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      n_fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      summary();
    end
  end

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic set_idle(input string tag);
    exp_cs = 1'b1; exp_sclk = 1'b0; exp_busy = 1'b0; exp_valid = 1'b0; cur_tag = tag;
  endtask

  int stepno, abort_at, start_at;
  logic aborted;

  task automatic step(input logic ecs, input logic esclk, input string tag);
    logic ab;
    exp_cs = ecs; exp_sclk = esclk; exp_busy = 1'b1; exp_valid = 1'b0; cur_tag = tag;
    if (stepno == abort_at) abort = 1'b1;
    if (stepno == start_at) start = 1'b1;
    cyc();
    ab = abort;
    abort = 1'b0;
    start = 1'b0;
    if (ab) aborted = 1'b1;
    stepno++;
  endtask

  task automatic run_read(input int d, input int g, input int nbusy,
                          input logic [23:0] f, input int ab_at, input int st_at);
    div_cfg = 8'(d); gap_cfg = 16'(g);
    conv_frame = f; polls_left = nbusy;
    stepno = 0; abort_at = ab_at; start_at = st_at; aborted = 1'b0;
    set_idle("R2");
    cyc();
    start = 1'b1;
    cyc();
    start = 1'b0;
    for (int p = 0; p <= nbusy && !aborted; p++) begin
      for (int i = 0; i <= d && !aborted; i++) step(1'b0, 1'b0, "R2");
      if (p < nbusy)
        for (int i = 0; i <= g && !aborted; i++) step(1'b1, 1'b0, "R3");
    end
    for (int h = 0; h < 48 && !aborted; h++)
      for (int i = 0; i <= d && !aborted; i++) step(1'b0, h[0], "R4");
    if (aborted) begin
      set_idle("R10");
      cyc();
      cyc();
    end else begin
      exp_cs = 1'b1; exp_sclk = 1'b0; exp_busy = 1'b1; exp_valid = 1'b1;
      exp_frame = f; cur_tag = "R5";
      cyc();
      set_idle("R5");
      cyc();
    end
  endtask

  initial begin
    chk_on = 1'b1;
    repeat (3) cyc();
    // R1: reset state observed by the per-cycle compare above
    rst_n = 1'b1;
    for (int i = 0; i < PWR; i++) begin
      if (i == 5) start = 1'b1;   // R2: start during power-up is ignored
      cyc();
      start = 1'b0;
    end
    set_idle("R1");
    cyc();
    cyc();
    // R7/R9: positive in-range value after two busy polls (R3)
    run_read(1, 3, 2, 24'h212345, -1, -1);
    // R9: negative value; R2: start pulse in the middle of the shift is ignored
    run_read(0, 0, 0, 24'h1FFFF0, -1, 30);
    // R8/R9: overrange clamps high
    run_read(2, 0, 0, 24'h300005, -1, -1);
    // R8/R9: underrange clamps low
    run_read(0, 0, 1, 24'h0ABCDE, -1, -1);
    // R6: dummy bit read high
    run_read(0, 0, 0, 24'h612345, -1, -1);
    // R10: abort in the middle of the shift phase
    run_read(1, 0, 0, 24'h212345, 12, -1);
    // R10: abort during the retry gap
    run_read(0, 4, 3, 24'h212345, 3, -1);
    // R10: normal read after an abort
    run_read(0, 1, 0, 24'h200000, -1, -1);
    chk_on = 1'b0;
    summary();
  end
endmodule